// File: doc/BRIEF.md
# Eye-Open Decision from Extremum Triples

This block makes the final open-or-closed decision for one eye image. An earlier stage has found the local maxima and minima of a smoothed column-brightness profile. It has stored, for each extremum, a type bit (1 for a maximum, 0 for a minimum), a value and a column index. Those lists sit on the block's inputs and stay steady while it works.

A `start` pulse begins a scan. A window counter moves a three-entry window over the lists, one position per clock. For each position, three selectors pick out the entry at the counter value and the two entries after it. The window qualifies when it holds a maximum, then a minimum, then a maximum. For a qualifying window the block takes the smaller of the two maxima and tests whether the minimum lies far enough below it. It also tests whether the minimum's column lies near the middle of the padded profile. The contrast test uses only shifts, adds and one comparison.

A flag latches high the first time a window passes both tests. Once high it blocks any further capture until the next scan. After the last window position, `done` pulses for one cycle. At that moment `eye_open` holds the decision for the frame.

Top module: `eye_open_check`

## Requirements
- R1: After reset, `eye_open` and `done` are both 0.
- R2: A `start` seen while idle clears `eye_open`. The block then evaluates window positions 0 to N_ENT-3, one per clock, and raises `done` for exactly one cycle after N_ENT-2 clocks (18 with defaults).
- R3: A window qualifies only if its type bits, from first to third entry, are 1, 0, 1 (type bit i is `ext_type[i]`, 1 meaning maximum). Patterns such as 0,1,0 or 1,1,1 never set `eye_open`.
- R4: The reference level is the smaller of the two maxima's values. A window whose minimum is deep enough against the larger maximum but not against the smaller one fails.
- R5: The contrast test passes when 256·(Ysmax−Ymin) > 12·Ysmax, with Ymin the middle entry's value (`ext_val[i*VAL_W +: VAL_W]`). For Ysmax = 1000, Ymin = 953 passes and 954 fails. Full-scale 15-bit values (32767 over 0) are computed without overflow and pass.
- R6: The middle entry's index (`ext_idx[i*IDX_W +: IDX_W]`) must satisfy 61 < Xmin < 92 (0.4 and 0.6 of a padded length of 153). 62 and 91 pass; 61 and 92 fail.
- R7: A window position p takes part only when p+2 < `ext_count`. A passing triple beyond the valid count does not set `eye_open`.
- R8: Once `eye_open` is set during a scan, it stays set for the rest of that scan and after `done`, until the next accepted `start`.
- R9: A `start` pulse during a scan is ignored. The scan and the `done` timing continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted when idle) |
| ext_count | input | CNT_W (5) | Number of valid extrema in the lists |
| ext_type | input | N_ENT (20) | Type bits, 1 = maximum, 0 = minimum |
| ext_val | input | N_ENT*VAL_W (300) | Packed extremum values, entry i at bits i*VAL_W |
| ext_idx | input | N_ENT*IDX_W (160) | Packed extremum column indices, entry i at bits i*IDX_W |
| eye_open | output | 1 | Latched decision: 1 = open |
| done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
A window counter that skips a step, stalls or stops at the wrong place shows up at once in the `done` timing, which is measured to the exact clock. A wrong selector offset or pattern decode appears in the final `eye_open` of the first scan whose passing triple sits next to a failing neighbour. Errors in the contrast or location arithmetic show as a wrong decision on the boundary frames: Ymin 953 against 954, Xmin 61, 62, 91 and 92, and full-scale values. A capture flag that does not hold is caught the first time a passing window is followed by failing ones.

// File: rtl/eye_chk_pkg.sv
package eye_chk_pkg;

  // Window pattern: first entry max, middle min, last max.
  localparam logic [2:0] MMM_PATTERN = 3'b101;

  // Contrast constant: theta ~ 0.05 scaled by 256 gives 2^3 + 2^2.
  localparam int DIFF_SHIFT = 8;
  localparam int REF_SHIFT_A = 3;
  localparam int REF_SHIFT_B = 2;

  // Strict lower bound on the centre index: floor(0.4 * len).
  function automatic int loc_low(input int zp_len);
    return (2 * zp_len) / 5;
  endfunction

  // Strict upper bound on the centre index: ceil(0.6 * len).
  function automatic int loc_high(input int zp_len);
    return (3 * zp_len + 4) / 5;
  endfunction

endpackage

// File: rtl/eye_win_sel.sv
module eye_win_sel #(
  parameter int N_ENT = 20,
  parameter int VAL_W = 15,
  parameter int IDX_W = 8,
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0]       base,
  input  logic [N_ENT-1:0]       typ_i,
  input  logic [N_ENT*VAL_W-1:0] val_i,
  input  logic [N_ENT*IDX_W-1:0] idx_i,
  output logic [2:0]             typ_o,
  output logic [3*VAL_W-1:0]     val_o,
  output logic [3*IDX_W-1:0]     idx_o
);

  // Three selectors addressed by base, base+1, base+2.
  // Lane 0 maps to typ_o[2] so the pattern reads left to right.
  for (genvar k = 0; k < 3; k++) begin : g_lane
    int unsigned addr;
    always_comb begin
      addr = int'(base) + k;
      if (addr >= N_ENT) addr = 0;
      typ_o[2-k]              = typ_i[addr];
      val_o[k*VAL_W +: VAL_W] = val_i[addr*VAL_W +: VAL_W];
      idx_o[k*IDX_W +: IDX_W] = idx_i[addr*IDX_W +: IDX_W];
    end
  end

endmodule

// File: rtl/eye_cond_eval.sv
module eye_cond_eval
  import eye_chk_pkg::*;
#(
  parameter int VAL_W  = 15,
  parameter int IDX_W  = 8,
  parameter int ZP_LEN = 153
) (
  input  logic [2:0]         typ3,
  input  logic [3*VAL_W-1:0] val3,
  input  logic [3*IDX_W-1:0] idx3,
  output logic               pass
);

  localparam int CW = VAL_W + DIFF_SHIFT + 1;
  localparam int LO = loc_low(ZP_LEN);
  localparam int HI = loc_high(ZP_LEN);

  logic [VAL_W-1:0] v_left, v_mid, v_right, ysmax;
  logic [IDX_W-1:0] x_mid;
  logic [CW-1:0]    diff_w, ys_w, lhs, rhs;
  logic             pat_ok, con_ok, loc_ok;

  always_comb begin
    v_left  = val3[0 +: VAL_W];
    v_mid   = val3[VAL_W +: VAL_W];
    v_right = val3[2*VAL_W +: VAL_W];
    x_mid   = idx3[IDX_W +: IDX_W];
    ysmax   = (v_left < v_right) ? v_left : v_right;
    ys_w    = CW'(ysmax);
    diff_w  = CW'(ysmax) - CW'(v_mid);
    lhs     = diff_w << DIFF_SHIFT;
    rhs     = (ys_w << REF_SHIFT_A) + (ys_w << REF_SHIFT_B);
    pat_ok  = (typ3 == MMM_PATTERN);
    con_ok  = (ysmax > v_mid) && (lhs > rhs);
    loc_ok  = (int'(x_mid) > LO) && (int'(x_mid) < HI);
    pass    = pat_ok && con_ok && loc_ok;
  end

endmodule

// File: rtl/eye_open_check.sv
module eye_open_check #(
  parameter int N_ENT  = 20,
  parameter int VAL_W  = 15,
  parameter int IDX_W  = 8,
  parameter int ZP_LEN = 153,
  parameter int CNT_W  = $clog2(N_ENT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [CNT_W-1:0]       ext_count,
  input  logic [N_ENT-1:0]       ext_type,
  input  logic [N_ENT*VAL_W-1:0] ext_val,
  input  logic [N_ENT*IDX_W-1:0] ext_idx,
  output logic                   eye_open,
  output logic                   done
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(N_ENT - 3);

  logic                 busy;
  logic [CNT_W-1:0]     win;
  logic [2:0]           typ3;
  logic [3*VAL_W-1:0]   val3;
  logic [3*IDX_W-1:0]   idx3;
  logic [CNT_W:0]       far_pos;
  logic                 in_range, pass, capture;

  eye_win_sel #(
    .N_ENT(N_ENT), .VAL_W(VAL_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_sel (
    .base(win), .typ_i(ext_type), .val_i(ext_val), .idx_i(ext_idx),
    .typ_o(typ3), .val_o(val3), .idx_o(idx3)
  );

  eye_cond_eval #(
    .VAL_W(VAL_W), .IDX_W(IDX_W), .ZP_LEN(ZP_LEN)
  ) u_eval (
    .typ3(typ3), .val3(val3), .idx3(idx3), .pass(pass)
  );

  always_comb begin
    far_pos  = {1'b0, win} + (CNT_W+1)'(2);
    in_range = far_pos < {1'b0, ext_count};
    // The latched flag masks its own capture path.
    capture  = busy && in_range && pass && !eye_open;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      win      <= '0;
      eye_open <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        win      <= '0;
        eye_open <= 1'b0;
      end else if (busy) begin
        if (capture) eye_open <= 1'b1;
        if (win == LAST_POS) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          win <= win + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/eye_open_check_sva.sv
module eye_open_check_sva
  import eye_chk_pkg::*;
#(
  parameter int N_ENT  = 20,
  parameter int IDX_W  = 8,
  parameter int ZP_LEN = 153,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic [CNT_W-1:0] win,
  input logic [CNT_W-1:0] ext_count,
  input logic             pass,
  input logic [IDX_W-1:0] x_mid,
  input logic             eye_open,
  input logic             done
);

  localparam int LO = loc_low(ZP_LEN);
  localparam int HI = loc_high(ZP_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(N_ENT - 3);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!eye_open && !done));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!eye_open && busy && win == '0));

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_centre_bounds: assert property (@(posedge clk) disable iff (rst)
    (busy && pass) |-> (int'(x_mid) > LO && int'(x_mid) < HI));

  a_r7_beyond_count: assert property (@(posedge clk) disable iff (rst)
    (busy && !eye_open && (int'(win) + 2 >= int'(ext_count))) |=> !eye_open);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (eye_open && !(start && !busy)) |=> eye_open);

  a_r9_scan_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && win != LAST_POS) |=> (busy && win == $past(win) + 1'b1));

endmodule

bind eye_open_check eye_open_check_sva #(
  .N_ENT(N_ENT), .IDX_W(IDX_W), .ZP_LEN(ZP_LEN), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .win(win),
  .ext_count(ext_count), .pass(pass), .x_mid(idx3[IDX_W +: IDX_W]),
  .eye_open(eye_open), .done(done)
);

// File: tb/sim_eye_open_check.sv
module sim_eye_open_check;

  localparam int N_ENT = 20;
  localparam int VAL_W = 15;
  localparam int IDX_W = 8;
  localparam int CNT_W = 5;
  localparam int SCAN_CYC = N_ENT - 2;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   start = 1'b0;
  logic [CNT_W-1:0]       ext_count = CNT_W'(N_ENT);
  logic [N_ENT-1:0]       ext_type = '0;
  logic [N_ENT*VAL_W-1:0] ext_val = '0;
  logic [N_ENT*IDX_W-1:0] ext_idx = '0;
  logic                   eye_open, done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  eye_open_check #(.N_ENT(N_ENT), .VAL_W(VAL_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .ext_count(ext_count),
    .ext_type(ext_type), .ext_val(ext_val), .ext_idx(ext_idx),
    .eye_open(eye_open), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_lists();
    ext_type  = '0;
    ext_val   = '0;
    ext_idx   = '0;
    ext_count = CNT_W'(N_ENT);
  endtask

  task automatic put(input int i, input bit t, input int v, input int x);
    ext_type[i]              = t;
    ext_val[i*VAL_W +: VAL_W] = VAL_W'(v);
    ext_idx[i*IDX_W +: IDX_W] = IDX_W'(x);
  endtask

  task automatic put_triple(input int p, input bit t0, input bit t1, input bit t2,
                            input int v0, input int v1, input int v2, input int x);
    put(p, t0, v0, 10);
    put(p + 1, t1, v1, x);
    put(p + 2, t2, v2, 140);
  endtask

  // Pulse start, then count clocks until done; check timing, pulse width, result.
  task automatic run_scan(input string req, input int exp_open);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
    check("R2 done timing", n, SCAN_CYC);
    check(req, int'(eye_open), exp_open);
    @(negedge clk);
    check("R2 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    check("R1 open after reset", int'(eye_open), 0);
    check("R1 done after reset", int'(done), 0);
  endtask

  task automatic t_basic();
    clear_lists();
    put_triple(0, 1, 0, 1, 1000, 900, 1200, 80);
    run_scan("R3 basic open", 1);
    put_triple(4, 1, 0, 1, 1000, 900, 1200, 80);
    put_triple(0, 0, 1, 0, 1000, 900, 1200, 80);
    ext_type[4] = 1'b0; ext_type[5] = 1'b1; ext_type[6] = 1'b0;
    run_scan("R3 pattern 0,1,0 rejected", 0);
    clear_lists();
    put_triple(3, 1, 1, 1, 1000, 900, 1200, 80);
    run_scan("R3 pattern 1,1,1 rejected", 0);
  endtask

  task automatic t_ysmax();
    clear_lists();
    put_triple(2, 1, 0, 1, 1000, 954, 5000, 80);
    run_scan("R4 smaller maximum is reference", 0);
    put_triple(2, 1, 0, 1, 5000, 954, 1000, 80);
    run_scan("R4 smaller maximum on right", 0);
  endtask

  task automatic t_contrast();
    clear_lists();
    put_triple(1, 1, 0, 1, 1000, 953, 1000, 80);
    run_scan("R5 contrast 953 passes", 1);
    put_triple(1, 1, 0, 1, 1000, 954, 1000, 80);
    run_scan("R5 contrast 954 fails", 0);
    put_triple(1, 1, 0, 1, 32767, 0, 32767, 80);
    run_scan("R5 full scale no overflow", 1);
    put_triple(1, 1, 0, 1, 1000, 1100, 1000, 80);
    run_scan("R5 minimum above maxima fails", 0);
  endtask

  task automatic t_location();
    clear_lists();
    put_triple(6, 1, 0, 1, 2000, 1000, 2000, 61);
    run_scan("R6 index 61 rejected", 0);
    put_triple(6, 1, 0, 1, 2000, 1000, 2000, 62);
    run_scan("R6 index 62 accepted", 1);
    put_triple(6, 1, 0, 1, 2000, 1000, 2000, 91);
    run_scan("R6 index 91 accepted", 1);
    put_triple(6, 1, 0, 1, 2000, 1000, 2000, 92);
    run_scan("R6 index 92 rejected", 0);
  endtask

  task automatic t_count();
    clear_lists();
    put_triple(5, 1, 0, 1, 2000, 1000, 2000, 70);
    ext_count = 5'd7;
    run_scan("R7 triple beyond count ignored", 0);
    ext_count = 5'd8;
    run_scan("R7 triple within count used", 1);
    clear_lists();
    put_triple(17, 1, 0, 1, 2000, 1000, 2000, 70);
    run_scan("R2 last window position evaluated", 1);
  endtask

  task automatic t_sticky();
    int lost;
    clear_lists();
    put_triple(0, 1, 0, 1, 2000, 1000, 2000, 70);
    // Later failing windows must not clear the flag.
    put_triple(8, 1, 0, 1, 2000, 1999, 2000, 70);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 start clears flag", int'(eye_open), 0);
    lost = 0;
    @(negedge clk);
    for (int k = 0; k < SCAN_CYC + 3; k++) begin
      if (!eye_open) lost++;
      @(negedge clk);
    end
    check("R8 flag held through and after scan", lost, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8 flag cleared by next start", int'(eye_open), 0);
    repeat (SCAN_CYC + 2) @(negedge clk);
  endtask

  task automatic t_busy_start();
    int n;
    clear_lists();
    put_triple(10, 1, 0, 1, 2000, 1000, 2000, 70);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n++;
      if (n == 12) start = 1'b1;
      if (n == 13) start = 1'b0;
      if (done) break;
    end
    check("R9 start while busy ignored (timing)", n, SCAN_CYC);
    check("R9 start while busy keeps result", int'(eye_open), 1);
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ysmax();
    t_contrast();
    t_location();
    t_count();
    t_sticky();
    t_busy_start();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule